// File: doc/BRIEF.md
# Output Compare Force Strobe Unit

This block is the waveform stage of one output-compare channel on a 16-bit timer. It owns the channel's output pin register and decides, every clock, whether a compare action happens. An action comes from one of two places: a real compare-match pulse from the counter comparator, or a write-only force strobe from software. The 2-bit compare output mode selects what the action does to the pin.

A real match does three things. It applies the pin action, it raises a one-cycle interrupt-flag set pulse, and it requests a timer clear when clear-on-compare mode is enabled. A force strobe only moves the pin. It never raises the interrupt pulse and never clears the timer.

While the timer runs a PWM waveform mode, this stage leaves the pin alone, because PWM waveforms are produced elsewhere. All outputs are registered, so each one responds on the clock after the input that caused it.

Top module: `oc_force_stage`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, `oc_pin`, `irq_set` and `timer_clr` are 0.
- R2: A force strobe in non-PWM mode changes `oc_pin` on the next cycle according to `com_mode`. The encoding is 2'b00 no change, 2'b01 invert, 2'b10 drive 0, 2'b11 drive 1.
- R3: A real match in non-PWM mode changes `oc_pin` on the next cycle, using the same `com_mode` encoding as R2.
- R4: A force strobe without a real match leaves `irq_set` at 0 on the next cycle.
- R5: A force strobe without a real match leaves `timer_clr` at 0 on the next cycle, even with `ctc_mode` high.
- R6: While `pwm_mode` is high, neither a force strobe nor a match changes `oc_pin`.
- R7: A real match makes `irq_set` 1 for exactly the next cycle, whatever the mode.
- R8: `timer_clr` is 1 on the cycle after a real match taken while `ctc_mode` is high, and 0 otherwise.
- R9: When a match and a force strobe arrive in the same cycle, the pin action is applied once (invert mode inverts once), and `irq_set` still pulses.
- R10: The force bit's readback, `force_rdata`, is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_pulse | input | 1 | One-cycle real compare-match event |
| force_wr | input | 1 | Software write of 1 to the force bit |
| com_mode | input | 2 | Compare output mode (00 none, 01 invert, 10 clear, 11 set) |
| pwm_mode | input | 1 | High while a PWM waveform mode is selected |
| ctc_mode | input | 1 | High while clear-on-compare mode is selected |
| oc_pin | output | 1 | Registered compare output |
| irq_set | output | 1 | One-cycle pulse that sets the compare interrupt flag |
| timer_clr | output | 1 | One-cycle request to clear the counter |
| force_rdata | output | 1 | Readback value of the force bit |

## Verification
Directed phases drive the force strobe alone through all four modes. They repeat the same four modes with a real match alone, and again with both events together in invert mode. A lone force that does not also change `irq_set` or `timer_clr` shows the two sources are kept apart. A single inversion on coincident events shows they are merged rather than applied twice. Force and match under `pwm_mode`, and matches with and without `ctc_mode`, show that the mode gating is applied. A long random phase then compares every output against a behavioural model on every clock.

// File: rtl/oc_force_pkg.sv
package oc_force_pkg;

  typedef enum logic [1:0] {
    COM_NONE   = 2'b00,
    COM_INVERT = 2'b01,
    COM_LOW    = 2'b10,
    COM_HIGH   = 2'b11
  } com_mode_e;

  typedef struct packed {
    logic act;
    logic irq;
    logic clr;
  } oc_req_t;

endpackage

// File: rtl/oc_event_merge.sv
module oc_event_merge
  import oc_force_pkg::*;
(
  input  logic    match_pulse,
  input  logic    force_wr,
  input  logic    pwm_mode,
  input  logic    ctc_mode,
  output oc_req_t req
);
  always_comb begin
    // Both sources fold into one action, so a coincident pair acts once.
    req.act = (match_pulse | force_wr) & ~pwm_mode;
    // Only the real match reaches the interrupt and counter-clear paths.
    req.irq = match_pulse;
    req.clr = match_pulse & ctc_mode;
  end
endmodule

// File: rtl/oc_action_unit.sv
module oc_action_unit
  import oc_force_pkg::*;
(
  input  logic       cur_level,
  input  logic       apply,
  input  logic [1:0] mode,
  output logic       nxt_level
);
  com_mode_e mode_e;
  assign mode_e = com_mode_e'(mode);

  always_comb begin
    nxt_level = cur_level;
    if (apply) begin
      unique case (mode_e)
        COM_NONE:   nxt_level = cur_level;
        COM_INVERT: nxt_level = ~cur_level;
        COM_LOW:    nxt_level = 1'b0;
        COM_HIGH:   nxt_level = 1'b1;
        default:    nxt_level = cur_level;
      endcase
    end
  end
endmodule

// File: rtl/oc_force_stage.sv
module oc_force_stage
  import oc_force_pkg::*;
#(
  parameter logic PIN_RESET = 1'b0,
  parameter int   MODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              match_pulse,
  input  logic              force_wr,
  input  logic [MODE_W-1:0] com_mode,
  input  logic              pwm_mode,
  input  logic              ctc_mode,
  output logic              oc_pin,
  output logic              irq_set,
  output logic              timer_clr,
  output logic              force_rdata
);
  localparam int ACT_W = (MODE_W < 2) ? MODE_W : 2;

  oc_req_t req;
  logic    pin_nxt;
  logic    pin_q, irq_q, clr_q;

  oc_event_merge u_merge (
    .match_pulse (match_pulse),
    .force_wr    (force_wr),
    .pwm_mode    (pwm_mode),
    .ctc_mode    (ctc_mode),
    .req         (req)
  );

  oc_action_unit u_action (
    .cur_level (pin_q),
    .apply     (req.act),
    .mode      (com_mode[ACT_W-1:0]),
    .nxt_level (pin_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= PIN_RESET;
      irq_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      pin_q <= pin_nxt;
      irq_q <= req.irq;
      clr_q <= req.clr;
    end
  end

  assign oc_pin      = pin_q;
  assign irq_set     = irq_q;
  assign timer_clr   = clr_q;
  // The force bit is a write strobe with no storage behind it.
  assign force_rdata = 1'b0;

  // R4
  force_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (force_wr && !match_pulse) |=> !irq_set);
  // R5
  force_no_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (force_wr && !match_pulse) |=> !timer_clr);
  // R6
  pwm_pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_mode |=> $stable(oc_pin));
  // R7
  match_irq_chk: assert property (@(posedge clk) disable iff (rst)
    match_pulse |=> irq_set);
  // R8
  ctc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (match_pulse && ctc_mode) |=> timer_clr);
  // R8
  no_ctc_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !ctc_mode |=> !timer_clr);
  // R2
  mode_none_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (com_mode[ACT_W-1:0] == 2'b00) |=> $stable(oc_pin));
  // R2
  mode_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((match_pulse || force_wr) && !pwm_mode && com_mode[ACT_W-1:0] == 2'b11) |=> oc_pin);
  // R9
  dual_invert_once_chk: assert property (@(posedge clk) disable iff (rst)
    (match_pulse && force_wr && !pwm_mode && com_mode[ACT_W-1:0] == 2'b01)
      |=> (oc_pin != $past(oc_pin)));
endmodule

// File: tb/oc_force_stage_tb_top.sv
`timescale 1ns/1ps
module oc_force_stage_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       match_pulse = 1'b0;
  logic       force_wr = 1'b0;
  logic [1:0] com_mode = 2'b00;
  logic       pwm_mode = 1'b0;
  logic       ctc_mode = 1'b0;
  logic       oc_pin, irq_set, timer_clr, force_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int exp_pin = 0;
  int exp_irq = 0;
  int exp_clr = 0;

  always #2.5 clk = ~clk;

  oc_force_stage dut_i (
    .clk(clk), .rst(rst), .match_pulse(match_pulse), .force_wr(force_wr),
    .com_mode(com_mode), .pwm_mode(pwm_mode), .ctc_mode(ctc_mode),
    .oc_pin(oc_pin), .irq_set(irq_set), .timer_clr(timer_clr),
    .force_rdata(force_rdata)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit m, bit f, int mode, bit p, bit c);
    string pin_tag, irq_tag, clr_tag;
    match_pulse = m; force_wr = f; com_mode = mode[1:0];
    pwm_mode = p; ctc_mode = c;
    if (p && (m || f))  pin_tag = "R6";
    else if (m && f)    pin_tag = "R9";
    else if (m)         pin_tag = "R3";
    else                pin_tag = "R2";
    irq_tag = (f && !m) ? "R4" : ((m && f) ? "R9" : "R7");
    clr_tag = (f && !m && c) ? "R5" : "R8";
    if (!p && (m || f)) begin
      case (mode)
        1: exp_pin = 1 - exp_pin;
        2: exp_pin = 0;
        3: exp_pin = 1;
        default: ;
      endcase
    end
    exp_irq = m;
    exp_clr = (m && c) ? 1 : 0;
    @(negedge clk);
    check(pin_tag, oc_pin, exp_pin);
    check(irq_tag, irq_set, exp_irq);
    check(clr_tag, timer_clr, exp_clr);
    check("R10", force_rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", oc_pin, 0);
    check("R1", irq_set, 0);
    check("R1", timer_clr, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", oc_pin, 0);
    check("R1", irq_set, 0);
    check("R1", timer_clr, 0);
    // R2: force alone through each mode, CTC on to show no clear (R5)
    step(0, 1, 3, 0, 1);
    step(0, 1, 0, 0, 1);
    step(0, 1, 1, 0, 1);
    step(0, 1, 1, 0, 1);
    step(0, 1, 2, 0, 0);
    step(0, 0, 3, 0, 0);
    // R3: real match through each mode
    step(1, 0, 3, 0, 0);
    step(1, 0, 0, 0, 1);
    step(1, 0, 2, 0, 1);
    step(1, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    // R9: coincident events in invert mode
    step(1, 1, 1, 0, 1);
    step(1, 1, 1, 0, 0);
    // R6: PWM mode gating
    step(0, 1, 1, 1, 0);
    step(1, 0, 3, 1, 1);
    step(1, 1, 2, 1, 0);
    step(0, 0, 0, 0, 0);
    // random phase against the model
    for (int i = 0; i < 2000; i++)
      step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3),
           ($urandom_range(0, 3) == 0), $urandom_range(0, 1));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule